// File: doc/BRIEF.md
# SIMD Lane-Partitioned Multiply-High Unit

This block multiplies two 128-bit vectors lane by lane and keeps the upper half of each double-width product. The vector splits into sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. Each lane treats its elements as signed or unsigned. Each lane can truncate the product, or round it by adding half of the weight that the shift discards. A small decoder takes a 32-bit instruction word and pulls out three controls: element size, signedness and rounding.

The result is registered and offered under a valid/ready handshake. A 16-bit byte-enable mask chooses which destination bytes take the new value. Every disabled byte keeps the value supplied on the previous-destination input. An element-size code of 2'b11 is illegal: it raises a flag and writes no byte.

The control sits in a two-state machine. In ST_IDLE the unit is ready. On an accepted input (transition ACCEPT) the output register loads and the machine enters ST_FULL. It stays in ST_FULL (transition STALL) while the consumer holds ready low. When the consumer takes the result (transition DRAIN), the machine returns to ST_IDLE. While ST_IDLE sees no valid input it stays where it is (transition WAIT).

Top module: `simd_mulhi_unit`

## Requirements
- R1: The instruction word is decoded as follows. Bit 28 = 1 selects unsigned and 0 selects signed. Bit 12 = 1 selects rounding and 0 selects truncating. Bits 21:20 give the element size: 00 = 8, 01 = 16, 10 = 32. Every other instruction bit has no effect on the result.
- R2: In signed truncating mode, each lane result is the low esize bits of (a*b) >> esize. Both elements are sign-extended and the shift is arithmetic.
- R3: In unsigned mode, elements are zero-extended before the multiply.
- R4: In rounding mode, 2^(esize-1) is added to the full product before the shift by esize. The lane keeps the low esize bits of that value.
- R5: The product is formed at twice the element width, so no high bits are lost. For example, unsigned 32-bit 0xFFFFFFFF*0xFFFFFFFF gives 0xFFFFFFFE.
- R6: Lanes are independent. Lane i of size esize occupies result bits [i*esize +: esize], giving 16, 8 or 4 lanes.
- R7: If byte_en[i] = 1, result byte i takes the computed byte. If byte_en[i] = 0, result byte i equals dst_prev byte i.
- R8: With size code 11, illegal is 1 and result equals dst_prev in every byte. For the three legal codes, illegal is 0.
- R9: in_ready is 1 only in ST_IDLE. out_valid is 1 in the cycle after an accepted input (in_valid and in_ready at a clock edge).
- R10: While out_valid = 1 and out_ready = 0, out_valid, result and illegal hold their values. On out_valid and out_ready, out_valid falls at the next edge.
- R11: After reset, out_valid = 0, in_ready = 1, result = 0 and illegal = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and instruction present |
| in_ready | output | 1 | Unit can accept an input |
| insn | input | 32 | Instruction word carrying the controls |
| src_a | input | 128 | First vector operand |
| src_b | input | 128 | Second vector operand |
| dst_prev | input | 128 | Previous destination value, kept in disabled bytes |
| byte_en | input | 16 | Per-byte write enable |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 128 | Merged vector result |
| illegal | output | 1 | Size code 11 was presented |

## Verification
A result is due one clock edge after the edge that accepts it. The bench drives inputs on the falling edge, and at the next falling edge it drops in_valid and compares out_valid, result and illegal against an arithmetic model computed at 67-bit signed precision. Hold behaviour is checked across several falling edges with out_ready low. The 8-bit signed and unsigned, truncating and rounding modes are swept over every operand pair. The 16-bit and 32-bit sizes get extreme-value vectors plus random operands and masks.

// File: rtl/simd_mulhi_pkg.sv
package simd_mulhi_pkg;

    typedef enum logic [1:0] {
        ES_8   = 2'b00,
        ES_16  = 2'b01,
        ES_32  = 2'b10,
        ES_BAD = 2'b11
    } esize_e;

    typedef struct packed {
        logic   is_unsigned;
        logic   do_round;
        esize_e size;
        logic   illegal;
    } mulhi_ctrl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FULL = 1'b1
    } state_e;

    localparam int UNS_BIT   = 28;
    localparam int RND_BIT   = 12;
    localparam int SIZE_LSB  = 20;

endpackage

// File: rtl/simd_mulhi_decode.sv
module simd_mulhi_decode
    import simd_mulhi_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic [INSN_W-1:0] insn,
    output mulhi_ctrl_t       ctrl
);
    logic [1:0] size_bits;
    logic       unused_insn;

    assign size_bits   = insn[SIZE_LSB +: 2];
    assign unused_insn = ^insn;

    always_comb begin
        ctrl.is_unsigned = insn[UNS_BIT];
        ctrl.do_round    = insn[RND_BIT];
        ctrl.size        = esize_e'(size_bits);
        ctrl.illegal     = (size_bits == 2'b11);
    end
endmodule

// File: rtl/simd_mulhi_lane.sv
module simd_mulhi_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_unsigned,
    input  logic         do_round,
    output logic [W-1:0] hi
);
    localparam int PW = 2 * W + 2;

    logic                 a_sx, b_sx;
    logic signed [PW-1:0] a_ext, b_ext, prod, bias, total;
    logic                 unused_bits;

    assign a_sx = is_unsigned ? 1'b0 : a[W-1];
    assign b_sx = is_unsigned ? 1'b0 : b[W-1];

    // operands widened to the full product width keep every high bit
    assign a_ext = {{(W+2){a_sx}}, a};
    assign b_ext = {{(W+2){b_sx}}, b};
    assign prod  = a_ext * b_ext;

    always_comb begin
        bias = '0;
        if (do_round) bias[W-1] = 1'b1;
    end

    assign total       = prod + bias;
    assign hi          = total[2*W-1:W];
    assign unused_bits = ^{total[PW-1:2*W], total[W-1:0]};
endmodule

// File: rtl/simd_mulhi_array.sv
module simd_mulhi_array
    import simd_mulhi_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] va,
    input  logic [VEC_W-1:0] vb,
    input  mulhi_ctrl_t      ctrl,
    output logic [VEC_W-1:0] vres
);
    localparam int N8  = VEC_W / 8;
    localparam int N16 = VEC_W / 16;
    localparam int N32 = VEC_W / 32;

    logic [VEC_W-1:0] res8, res16, res32;

    for (genvar i = 0; i < N8; i++) begin : g_l8
        simd_mulhi_lane #(.W(8)) lane_i (
            .a(va[i*8 +: 8]), .b(vb[i*8 +: 8]),
            .is_unsigned(ctrl.is_unsigned), .do_round(ctrl.do_round),
            .hi(res8[i*8 +: 8])
        );
    end

    for (genvar i = 0; i < N16; i++) begin : g_l16
        simd_mulhi_lane #(.W(16)) lane_i (
            .a(va[i*16 +: 16]), .b(vb[i*16 +: 16]),
            .is_unsigned(ctrl.is_unsigned), .do_round(ctrl.do_round),
            .hi(res16[i*16 +: 16])
        );
    end

    for (genvar i = 0; i < N32; i++) begin : g_l32
        simd_mulhi_lane #(.W(32)) lane_i (
            .a(va[i*32 +: 32]), .b(vb[i*32 +: 32]),
            .is_unsigned(ctrl.is_unsigned), .do_round(ctrl.do_round),
            .hi(res32[i*32 +: 32])
        );
    end

    always_comb begin
        unique case (ctrl.size)
            ES_8:    vres = res8;
            ES_16:   vres = res16;
            ES_32:   vres = res32;
            default: vres = '0;
        endcase
    end
endmodule

// File: rtl/simd_mulhi_unit.sv
module simd_mulhi_unit
    import simd_mulhi_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int INSN_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [INSN_W-1:0]  insn,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic [VEC_W-1:0]   dst_prev,
    input  logic [VEC_W/8-1:0] byte_en,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [VEC_W-1:0]   result,
    output logic               illegal
);
    localparam int NBYTES = VEC_W / 8;

    mulhi_ctrl_t       ctrl;
    logic [VEC_W-1:0]  lane_out;
    logic [VEC_W-1:0]  merged;
    logic [NBYTES-1:0] wr_en;
    logic              accept;
    state_e            state, state_nx;

    simd_mulhi_decode #(.INSN_W(INSN_W)) dec_i (
        .insn(insn),
        .ctrl(ctrl)
    );

    simd_mulhi_array #(.VEC_W(VEC_W)) arr_i (
        .va(src_a),
        .vb(src_b),
        .ctrl(ctrl),
        .vres(lane_out)
    );

    // an illegal size writes no destination byte
    assign wr_en = ctrl.illegal ? '0 : byte_en;

    for (genvar i = 0; i < NBYTES; i++) begin : g_merge
        assign merged[i*8 +: 8] = wr_en[i] ? lane_out[i*8 +: 8]
                                           : dst_prev[i*8 +: 8];
    end

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_FULL);
    assign accept    = in_valid && in_ready;

    // next state: WAIT, ACCEPT, STALL, DRAIN
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid)  state_nx = ST_FULL;
            ST_FULL: if (out_ready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else if (accept) begin
            result  <= merged;
            illegal <= ctrl.illegal;
        end
    end
endmodule

// File: rtl/simd_mulhi_chk.sv
module simd_mulhi_chk #(
    parameter int VEC_W  = 128,
    parameter int INSN_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [INSN_W-1:0]  insn,
    input logic [VEC_W-1:0]   dst_prev,
    input logic [VEC_W/8-1:0] byte_en,
    input logic               out_valid,
    input logic               out_ready,
    input logic [VEC_W-1:0]   result,
    input logic               illegal
);
    a_r9_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r9_no_ready_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(illegal)));

    a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

    a_r8_illegal_keeps_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && insn[21:20] == 2'b11)
        |=> (illegal && result == $past(dst_prev)));

    a_r7_no_enable_keeps_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && byte_en == '0) |=> (result == $past(dst_prev)));

    a_r8_legal_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && insn[21:20] != 2'b11) |=> !illegal);
endmodule

bind simd_mulhi_unit simd_mulhi_chk #(.VEC_W(VEC_W), .INSN_W(INSN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .dst_prev(dst_prev), .byte_en(byte_en),
    .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .illegal(illegal)
);

// File: tb/simd_mulhi_unit_tb.sv
`timescale 1ns/1ps
module simd_mulhi_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  insn = '0;
    logic [127:0] src_a = '0, src_b = '0, dst_prev = '0;
    logic [15:0]  byte_en = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] result;
    logic         illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    simd_mulhi_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .insn(insn), .src_a(src_a), .src_b(src_b), .dst_prev(dst_prev),
        .byte_en(byte_en), .out_valid(out_valid), .out_ready(out_ready),
        .result(result), .illegal(illegal)
    );

    function automatic logic [31:0] ref_lane(int w, logic [31:0] a, logic [31:0] b,
                                             bit uns, bit rnd);
        logic signed [66:0] ea, eb, p;
        logic [31:0] m;
        m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        ea = 67'(a & m);
        eb = 67'(b & m);
        if (!uns && a[w-1]) ea = ea - (67'sd1 <<< w);
        if (!uns && b[w-1]) eb = eb - (67'sd1 <<< w);
        p = ea * eb;
        if (rnd) p = p + (67'sd1 <<< (w - 1));
        p = p >>> w;
        return p[31:0] & m;
    endfunction

    function automatic logic [127:0] ref_vec(logic [1:0] sz, logic [127:0] a,
                                             logic [127:0] b, bit uns, bit rnd,
                                             logic [127:0] old, logic [15:0] en);
        logic [127:0] raw, outv;
        int w;
        raw = '0;
        if (sz == 2'b11) return old;
        w = 8 << sz;
        for (int l = 0; l < 128 / w; l++) begin
            logic [31:0] lv;
            lv = ref_lane(w, 32'(a >> (l * w)), 32'(b >> (l * w)), uns, rnd);
            for (int k = 0; k < w; k++) raw[l * w + k] = lv[k];
        end
        for (int i = 0; i < 16; i++)
            outv[i*8 +: 8] = en[i] ? raw[i*8 +: 8] : old[i*8 +: 8];
        return outv;
    endfunction

    function automatic logic [31:0] make_insn(bit uns, bit rnd, logic [1:0] sz,
                                              logic [31:0] filler);
        logic [31:0] v;
        v = filler;
        v[28] = uns;
        v[12] = rnd;
        v[21:20] = sz;
        return v;
    endfunction

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one transaction: drive at falling edge, result due after the next rising edge
    task automatic txn(bit uns, bit rnd, logic [1:0] sz, logic [127:0] a,
                       logic [127:0] b, logic [127:0] old, logic [15:0] en,
                       logic [31:0] filler, string req);
        logic [127:0] exp;
        exp = ref_vec(sz, a, b, uns, rnd, old, en);
        insn = make_insn(uns, rnd, sz, filler);
        src_a = a; src_b = b; dst_prev = old; byte_en = en;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R9 out_valid", 128'(out_valid), 128'd1);
        check(result == exp, req, result, exp);
        check(illegal == (sz == 2'b11), "R8 illegal flag", 128'(illegal),
              128'(sz == 2'b11));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset values
        check(out_valid == 1'b0, "R11 out_valid", 128'(out_valid), 128'd0);
        check(in_ready == 1'b1, "R11 in_ready", 128'(in_ready), 128'd1);
        check(result == '0, "R11 result", result, 128'd0);
        check(illegal == 1'b0, "R11 illegal", 128'(illegal), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R6: exhaustive 8-bit pairs in all four modes
        for (int mode = 0; mode < 4; mode++) begin
            for (int blk = 0; blk < 4096; blk++) begin
                logic [127:0] a, b;
                for (int l = 0; l < 16; l++) begin
                    int idx;
                    idx = blk * 16 + l;
                    a[l*8 +: 8] = 8'(idx >> 8);
                    b[l*8 +: 8] = 8'(idx);
                end
                txn(mode[1], mode[0], 2'b00, a, b, '0, 16'hFFFF, 32'h0,
                    mode[1] ? "R3 unsigned 8-bit" :
                    (mode[0] ? "R4 rounding 8-bit" : "R2 signed 8-bit"));
            end
        end

        // R5: double-width extremes at 32 and 16 bits
        for (int mode = 0; mode < 4; mode++) begin
            txn(mode[1], mode[0], 2'b10, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}},
                '0, 16'hFFFF, 32'h0, "R5 32-bit all ones");
            txn(mode[1], mode[0], 2'b10, {4{32'h8000_0000}}, {32'h7FFF_FFFF,
                32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF}, '0, 16'hFFFF,
                32'h0, "R5 32-bit extremes");
            txn(mode[1], mode[0], 2'b01, {8{16'h8000}}, {8{16'hFFFF}},
                '0, 16'hFFFF, 32'h0, "R5 16-bit extremes");
        end
        // R5 fixed expectation written out: 0xFFFFFFFF^2 unsigned -> 0xFFFFFFFE
        txn(1'b1, 1'b0, 2'b10, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, '0,
            16'hFFFF, 32'h0, "R5 literal");
        check(result == {4{32'hFFFF_FFFE}}, "R5 literal value", result,
              {4{32'hFFFF_FFFE}});

        // R1 R6 R7: random 16/32-bit operands, masks and filler bits
        for (int n = 0; n < 600; n++) begin
            logic [1:0] sz;
            sz = (n % 2 == 0) ? 2'b01 : 2'b10;
            txn(1'(n >> 1), 1'(n >> 2), sz, rnd128(), rnd128(), rnd128(),
                16'($urandom), $urandom, "R7 R1 random masked");
        end

        // R7: zero mask keeps destination
        txn(1'b0, 1'b1, 2'b10, rnd128(), rnd128(), 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE,
            16'h0000, 32'h0, "R7 zero mask");

        // R8: illegal size leaves destination untouched
        for (int n = 0; n < 4; n++)
            txn(1'(n), 1'(n >> 1), 2'b11, rnd128(), rnd128(), rnd128(),
                16'hFFFF, $urandom, "R8 illegal size");

        // R9 R10: hold while consumer stalls
        begin
            logic [127:0] a, b, exp;
            a = rnd128(); b = rnd128();
            exp = ref_vec(2'b01, a, b, 1'b0, 1'b0, '0, 16'hFFFF);
            insn = make_insn(1'b0, 1'b0, 2'b01, 32'h0);
            src_a = a; src_b = b; dst_prev = '0; byte_en = 16'hFFFF;
            check(out_valid == 1'b0, "R9 no valid before accept", 128'(out_valid), 128'd0);
            in_valid = 1'b1;
            @(negedge clk);
            check(out_valid == 1'b1, "R9 valid one cycle later", 128'(out_valid), 128'd1);
            for (int k = 0; k < 4; k++) begin
                src_a = rnd128();
                insn = make_insn(1'b1, 1'b1, 2'b00, $urandom);
                @(negedge clk);
                check(out_valid == 1'b1, "R10 valid held", 128'(out_valid), 128'd1);
                check(in_ready == 1'b0, "R9 not ready when full", 128'(in_ready), 128'd0);
                check(result == exp, "R10 result held", result, exp);
            end
            in_valid = 1'b0;
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            check(out_valid == 1'b0, "R10 drained", 128'(out_valid), 128'd0);
            check(in_ready == 1'b1, "R9 ready after drain", 128'(in_ready), 128'd1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule